// File: doc/BRIEF.md
# Timebase Edge Capture Channel

This block is one input-capture channel built around a 16-bit timebase counter that counts either up or down. An external capture pin is brought into the clock domain through a two-stage synchronizer. It can be gated off or inverted, and its rising and falling transitions are detected. Each detected transition stores the counter value of that cycle in its own register, one for rising and one for falling. Each transition direction can also restart the counter on its own. The restart value depends on the count direction: it is the period value when counting down and zero when counting up.

Software configures the channel and reads the captured values through a small register port. Each detected latch sets a sticky flag, and a write of 1 clears the flag. An interrupt line is raised when a set flag has its matching enable. A typical use is pulse-width or period measurement. With restart on the rising edge, the next falling capture gives the high time and the next rising capture gives the full period.

Top module: `pwm_capture_unit`

## Requirements
- R1: A level change on `cap_pin` passes a two-flop synchronizer and an edge detector. The matching capture register changes on the third rising clock edge after the pin changes. Each edge gives exactly one single-cycle latch pulse, and a rising and a falling pulse never coincide.
- R2: A rising latch copies the counter value of the detection cycle into RISE_CAP (address 2). A falling latch copies it into FALL_CAP (address 3). The stored value is taken before any restart caused by the same edge.
- R3: When CTRL bit 3 (rise restart) is set, a rising latch restarts the counter. When it is clear, the counter is left alone.
- R4: When CTRL bit 4 (fall restart) is set, a falling latch restarts the counter. When it is clear, the counter is left alone.
- R5: A restart loads PERIOD (address 1, bits 15:0) when CTRL bit 7 is 0 (count down). It loads 0 when CTRL bit 7 is 1 (count up).
- R6: While CTRL bit 8 (run) is set, the count-down counter decrements and goes from 0 to PERIOD. The count-up counter increments and goes from PERIOD, or any larger value, to 0. COUNT (address 5) shows the value in bits 15:0 and the direction in bit 16 (1 = up).
- R7: While CTRL bit 0 (pin enable) is 0, the pin is seen as a constant 0, so pin activity causes no capture.
- R8: While CTRL bit 1 (capture enable) is 0, detected edges cause no capture, no flag and no restart.
- R9: CTRL bit 2 inverts the pin before edge detection. With it set, a falling pin is captured as a rising edge, and a change of the bit alone can create an edge.
- R10: STATUS (address 4) bit 0 is the rising flag and bit 1 is the falling flag. Both are sticky, and writing 1 to a bit clears it. A latch in the same cycle as a clear leaves the flag set.
- R11: `irq` is a register that is 1 one cycle after a set rising flag meets CTRL bit 5 or a set falling flag meets CTRL bit 6.
- R12: After reset, the counter, both capture registers, the flags, CTRL and PERIOD are 0, so the count direction is down. `reg_rdata` is registered: it shows the register selected by `reg_addr` one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_pin | input | 1 | Asynchronous capture input |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Capture interrupt |

## Verification
The hardest situation to reach from the ports is a flag that is set and cleared in the same cycle. The latch happens two edges after the pin change and is hidden behind the synchronizer. The stimulus changes the pin on a falling clock edge, counts two rising edges and then presents the clear write, so both land on the third edge. Restart timing is pinned down by spacing two rising pin edges exactly 40 cycles apart with the counter running. The second capture must then show 39 steps from the restart value in either direction.

// File: rtl/cap_pkg.sv
package cap_pkg;
  localparam int REG_CTRL   = 0;
  localparam int REG_PERIOD = 1;
  localparam int REG_RISE   = 2;
  localparam int REG_FALL   = 3;
  localparam int REG_STATUS = 4;
  localparam int REG_COUNT  = 5;

  localparam int CTRL_W = 9;

  // packed: first field is the most significant bit (bit 8)
  typedef struct packed {
    logic run;
    logic up;
    logic fall_ie;
    logic rise_ie;
    logic fall_rld;
    logic rise_rld;
    logic inv;
    logic cap_en;
    logic pin_en;
  } ctrl_t;
endpackage

// File: rtl/cap_edge_detect.sv
module cap_edge_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic pin_en,
  input  logic inv,
  output logic rise,
  output logic fall
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic level;
  logic prev_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= pin;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
      end
    end
  endgenerate

  assign level = pin_en & (sync_q[SYNC_STAGES-1] ^ inv);

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= level;
  end

  assign rise = level & ~prev_q;
  assign fall = ~level & prev_q;

  // R1
  edges_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(rise && fall));
  // R1
  rise_single_chk: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
  // R1
  fall_single_chk: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall);
endmodule

// File: rtl/cap_timebase.sv
module cap_timebase #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             up,
  input  logic [CNT_W-1:0] period,
  input  logic             reload,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (reload) begin
      cnt <= up ? '0 : period;
    end else if (run) begin
      if (up) cnt <= (cnt >= period) ? '0 : cnt + ONE;
      else    cnt <= (cnt == '0) ? period : cnt - ONE;
    end
  end

  // R5
  reload_value_chk: assert property (@(posedge clk) disable iff (rst)
    reload |=> (cnt == ($past(up) ? '0 : $past(period))));
  // R6
  hold_when_stopped_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !reload) |=> $stable(cnt));
  // R6
  down_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !reload && !up && cnt == '0) |=> (cnt == $past(period)));
endmodule

// File: rtl/cap_regfile.sv
module cap_regfile
  import cap_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rise_lat,
  input  logic              fall_lat,
  input  logic [CNT_W-1:0]  cnt,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  period,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam int PAD_W = DATA_W - CNT_W;

  logic [CNT_W-1:0] rise_cap, fall_cap;
  logic rise_flag, fall_flag;
  logic wr_ctrl, wr_period, wr_status;
  logic unused_wbits;

  assign unused_wbits = ^wdata[DATA_W-1:CNT_W];
  assign wr_ctrl   = wr && (addr == ADDR_W'(REG_CTRL));
  assign wr_period = wr && (addr == ADDR_W'(REG_PERIOD));
  assign wr_status = wr && (addr == ADDR_W'(REG_STATUS));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl   <= '0;
      period <= '0;
    end else begin
      if (wr_ctrl)   ctrl   <= ctrl_t'(wdata[CTRL_W-1:0]);
      if (wr_period) period <= wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_cap <= '0;
      fall_cap <= '0;
    end else begin
      if (rise_lat) rise_cap <= cnt;
      if (fall_lat) fall_cap <= cnt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_flag <= 1'b0;
      fall_flag <= 1'b0;
    end else begin
      rise_flag <= rise_lat | (rise_flag & ~(wr_status & wdata[0]));
      fall_flag <= fall_lat | (fall_flag & ~(wr_status & wdata[1]));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= (rise_flag & ctrl.rise_ie) | (fall_flag & ctrl.fall_ie);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      case (addr)
        ADDR_W'(REG_CTRL):   rdata <= DATA_W'(ctrl);
        ADDR_W'(REG_PERIOD): rdata <= {{PAD_W{1'b0}}, period};
        ADDR_W'(REG_RISE):   rdata <= {{PAD_W{1'b0}}, rise_cap};
        ADDR_W'(REG_FALL):   rdata <= {{PAD_W{1'b0}}, fall_cap};
        ADDR_W'(REG_STATUS): rdata <= DATA_W'({fall_flag, rise_flag});
        ADDR_W'(REG_COUNT):  rdata <= DATA_W'({ctrl.up, cnt});
        default:             rdata <= '0;
      endcase
    end
  end

  // R2
  rise_capture_chk: assert property (@(posedge clk) disable iff (rst)
    rise_lat |=> (rise_cap == $past(cnt)));
  // R2
  fall_capture_chk: assert property (@(posedge clk) disable iff (rst)
    fall_lat |=> (fall_cap == $past(cnt)));
  // R10
  rise_flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    rise_lat |=> rise_flag);
  // R10
  fall_flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    fall_lat |=> fall_flag);
  // R11
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!rise_flag && !fall_flag) |=> !irq);
endmodule

// File: rtl/pwm_capture_unit.sv
module pwm_capture_unit
  import cap_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_pin,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] period;
  logic [CNT_W-1:0] cnt;
  logic             rise, fall;
  logic             rise_lat, fall_lat;
  logic             reload;

  cap_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .pin(cap_pin),
    .pin_en(ctrl.pin_en), .inv(ctrl.inv),
    .rise(rise), .fall(fall)
  );

  assign rise_lat = rise & ctrl.cap_en;
  assign fall_lat = fall & ctrl.cap_en;
  assign reload   = (rise_lat & ctrl.rise_rld) | (fall_lat & ctrl.fall_rld);

  cap_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst(rst), .run(ctrl.run), .up(ctrl.up),
    .period(period), .reload(reload), .cnt(cnt)
  );

  cap_regfile #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rise_lat(rise_lat), .fall_lat(fall_lat), .cnt(cnt),
    .ctrl(ctrl), .period(period), .rdata(reg_rdata), .irq(irq)
  );

  // R8
  no_latch_disabled_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl.cap_en |-> !(rise_lat || fall_lat || reload));
  // R3
  rise_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (rise_lat && ctrl.rise_rld && !ctrl.up) |=> (cnt == $past(period)));
endmodule

// File: tb/pwm_capture_unit_test.sv
`timescale 1ns/1ps
module pwm_capture_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cap_pin = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pwm_capture_unit uut (
    .clk(clk), .rst(rst), .cap_pin(cap_pin), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  typedef struct packed {
    logic [8:0]  ctrl;
    logic [15:0] period;
    logic        pin;
    logic [15:0] exp_rise;
    logic [15:0] exp_fall;
    logic [15:0] exp_cnt;
    logic [1:0]  exp_flags;
  } vec_t;

  // ctrl bits: 0 pin_en, 1 cap_en, 2 inv, 3 rise_rld, 4 fall_rld, 5 rise_ie, 6 fall_ie, 7 up, 8 run
  localparam vec_t VECS [8] = '{
    '{9'h00B, 16'd100, 1'b1, 16'd0,   16'd0,   16'd100, 2'b01}, // R2 R3 R5 rise restart down
    '{9'h00B, 16'd200, 1'b0, 16'd0,   16'd100, 16'd100, 2'b10}, // R2 R4 fall without restart
    '{9'h01B, 16'd300, 1'b1, 16'd100, 16'd100, 16'd300, 2'b01}, // R3 R5
    '{9'h093, 16'd300, 1'b0, 16'd100, 16'd300, 16'd0,   2'b10}, // R4 R5 up restart to 0
    '{9'h002, 16'd50,  1'b1, 16'd100, 16'd300, 16'd0,   2'b00}, // R7 pin gated
    '{9'h001, 16'd50,  1'b1, 16'd100, 16'd300, 16'd0,   2'b00}, // R8 capture off
    '{9'h00F, 16'd50,  1'b1, 16'd100, 16'd0,   16'd0,   2'b10}, // R9 invert makes falling
    '{9'h00F, 16'd50,  1'b0, 16'd0,   16'd0,   16'd50,  2'b01}  // R9 falling pin seen rising
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(posedge clk);
    #1 d = reg_rdata;
  endtask

  task automatic set_pin(input logic v);
    @(negedge clk);
    cap_pin = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic stream_count(input bit up_mode, input logic [15:0] per, input string req);
    logic [31:0] prev, cur;
    bit bad = 0;
    bit saw_wrap = 0;
    rd(3'd5, prev);
    for (int i = 0; i < 12; i++) begin
      @(posedge clk);
      #1 cur = reg_rdata;
      if (cur[16] !== up_mode) bad = 1;
      if (up_mode) begin
        if (cur[15:0] !== ((prev[15:0] >= per) ? 16'd0 : prev[15:0] + 16'd1)) bad = 1;
        if (prev[15:0] == per && cur[15:0] == 16'd0) saw_wrap = 1;
      end else begin
        if (cur[15:0] !== ((prev[15:0] == 16'd0) ? per : prev[15:0] - 16'd1)) bad = 1;
        if (prev[15:0] == 16'd0 && cur[15:0] == per) saw_wrap = 1;
      end
      prev = cur;
    end
    chk(req, {31'd0, bad}, 32'd0);
    chk(req, {31'd0, saw_wrap}, 32'd1);
  endtask

  task automatic elapsed(input logic [8:0] c, input logic [15:0] exp, input string req);
    logic [31:0] d;
    set_pin(1'b0);
    wr(3'd1, 32'd1000);
    wr(3'd0, {23'd0, c});
    idle(5);
    set_pin(1'b1);
    idle(20);
    cap_pin = 1'b0;
    idle(20);
    cap_pin = 1'b1;
    idle(5);
    rd(3'd2, d);
    chk(req, d, {16'd0, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R12 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      chk("R12 reset register", d, 32'd0);
    end
    chk("R12 reset irq", {31'd0, irq}, 32'd0);

    // vector table
    foreach (VECS[i]) begin
      wr(3'd4, 32'd3);
      wr(3'd1, {16'd0, VECS[i].period});
      wr(3'd0, {23'd0, VECS[i].ctrl});
      set_pin(VECS[i].pin);
      idle(5);
      rd(3'd2, d); chk("R2 rise capture", d, {16'd0, VECS[i].exp_rise});
      rd(3'd3, d); chk("R2 fall capture", d, {16'd0, VECS[i].exp_fall});
      rd(3'd5, d); chk("R5 counter", {16'd0, d[15:0]}, {16'd0, VECS[i].exp_cnt});
      rd(3'd4, d); chk("R10 flags", d, {30'd0, VECS[i].exp_flags});
    end

    // R11 interrupt
    wr(3'd0, 32'h023);
    idle(5);
    wr(3'd4, 32'd3);
    idle(3);
    chk("R11 irq idle", {31'd0, irq}, 32'd0);
    set_pin(1'b1);
    idle(5);
    chk("R11 irq on rising flag", {31'd0, irq}, 32'd1);
    wr(3'd4, 32'd1);
    idle(3);
    chk("R11 irq after clear", {31'd0, irq}, 32'd0);
    set_pin(1'b0);
    idle(5);
    chk("R11 fall flag without enable", {31'd0, irq}, 32'd0);
    rd(3'd4, d);
    chk("R10 sticky fall flag", d, 32'd2);

    // R10 set and clear in the same cycle
    wr(3'd4, 32'd3);
    set_pin(1'b1);
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd4; reg_wdata = 32'd1;
    @(negedge clk);
    reg_wr = 1'b0;
    rd(3'd4, d);
    chk("R10 set wins over clear", d, 32'd1);
    wr(3'd4, 32'd1);
    rd(3'd4, d);
    chk("R10 write one clears", d, 32'd0);

    // R6 free running count
    wr(3'd1, 32'd3);
    wr(3'd0, 32'h181);
    stream_count(1'b1, 16'd3, "R6 up count and wrap");
    wr(3'd0, 32'h101);
    stream_count(1'b0, 16'd3, "R6 down count and wrap");

    // R1 R3 restart timing with the counter running
    elapsed(9'h10B, 16'd961, "R1 R3 down elapsed capture");
    elapsed(9'h18B, 16'd39,  "R1 R3 up elapsed capture");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule